// File: doc/BRIEF.md
# Dual-Clock First-Word-Fall-Through FIFO

This block moves 36-bit words in one direction between two free-running clocks that have no fixed relation to each other. A producer on the write clock pushes words while Input Ready is high. A consumer on the read clock sees the oldest stored word already present on the read data port whenever Output Ready is high, and it takes that word by pulsing its read enable. Each port acts only when its select and its enable are both high. Each domain builds its own flags from its own binary pointer and from a two-flop synchronized Gray copy of the other domain's pointer, so the flags on each side are registered in the clock that uses them.

Two programmable thresholds drive the Almost-Full and Almost-Empty flags. They come out of reset at a default value. Software can reload them with one configuration write through the write port, or shift them in serially on the write clock. A retransmit hold marks the word at the head of the queue. A retransmit pulse then rewinds the read pointer to that mark, so words already read come out again. While the hold is high, the write side treats everything from the mark onward as occupied.

Top module: `dcfifo_fwft`

## Requirements
- R1: After words are written into an empty FIFO, Output Ready rises and the oldest word is presented on `rd_data` before any read is issued.
- R2: Words leave in the order they were written, with all 36 bits intact.
- R3: After DEPTH (default 512) stored words, Input Ready is low. A write attempted while Input Ready is low stores nothing.
- R4: A read attempted while Output Ready is low does not move the read pointer. A word written afterwards is still the first word presented.
- R5: Almost-Full is high when the number of free locations is at or below the full offset, and low otherwise. The full offset defaults to 8.
- R6: Almost-Empty is high when the number of stored words is at or below the empty offset, and low otherwise. The empty offset defaults to 8, and an empty FIFO always shows Almost-Empty.
- R7: During reset and after it, Output Ready is low and Almost-Empty is high. Input Ready stays low while reset is held and goes high once reset is released. Almost-Full is low.
- R8: A write with `wr_cfg` high loads the empty offset from `wr_data[9:0]` and the full offset from `wr_data[27:18]` (for the default depth). That write is not stored as data.
- R9: Each write clock with `ser_en` high shifts `ser_din` into the LSB of the 20-bit chain {full offset, empty offset}. The full offset MSB is sent first and the empty offset LSB is sent last.
- R10: When `rt_hold` rises, the current head word is marked. A one-cycle `rt_go` while the hold is high returns the read pointer to the mark, and the marked words are presented again in order.
- R11: While `rt_hold` is high, free space is counted from the mark, so no marked word can be overwritten. The read pointer seen by the write side moves by at most one location per read clock.
- R12: `wr_en` has no effect while `wr_sel` is low, and `rd_en` has no effect while `rd_sel` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset, sampled on both clocks |
| wr_sel | input | 1 | Write port select |
| wr_en | input | 1 | Write enable |
| wr_cfg | input | 1 | Turns a write into a parallel offset load |
| wr_data | input | 36 | Write data or offset fields |
| ser_en | input | 1 | Serial offset shift enable |
| ser_din | input | 1 | Serial offset data bit |
| in_rdy | output | 1 | Input Ready, space available |
| alm_full | output | 1 | Almost-Full flag |
| rd_sel | input | 1 | Read port select |
| rd_en | input | 1 | Read enable, takes the presented word |
| rt_hold | input | 1 | Retransmit mark hold |
| rt_go | input | 1 | Retransmit rewind pulse |
| rd_data | output | 36 | Head word, valid while Output Ready |
| out_rdy | output | 1 | Output Ready, head word valid |
| alm_empty | output | 1 | Almost-Empty flag |

## Verification
The assertions assume that offsets are loaded only while the FIFO is empty and idle, because the empty offset is used unsynchronized in the read domain. They also assume that a parallel load and a serial shift never happen in the same write cycle, and that `rt_go` is issued only while `rt_hold` is high. The stimulus does all programming between scenarios, after both sides have settled with an empty queue, and it drives every input half a period away from the sampling edge of its own clock. Two unrelated clock periods are used, so each crossing is exercised with real phase drift.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
// Shared helpers for the dual-clock FIFO: Gray conversion on a fixed
// maximum width. Callers zero-extend narrower pointers and truncate the result.
package dcf_pkg;
    localparam int GW = 16;

    // Binary to reflected Gray code.
    function automatic logic [GW-1:0] to_gray(input logic [GW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    // Reflected Gray code back to binary.
    function automatic logic [GW-1:0] from_gray(input logic [GW-1:0] g);
        logic [GW-1:0] b;
        b[GW-1] = g[GW-1];
        for (int i = GW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction
endpackage

// File: rtl/dcf_sync2.sv
`timescale 1ns/1ps
// Two-flop synchronizer for a Gray-coded pointer.
// Assumes the source changes at most one bit per source clock.
module dcf_sync2 #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Capture the foreign pointer through two stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/dcf_ofs_regs.sv
`timescale 1ns/1ps
// Almost-Full / Almost-Empty threshold registers in the write domain.
// Loaded in parallel from write-port fields or shifted in serially.
// Assumes loading happens only while the FIFO is empty and idle.
module dcf_ofs_regs #(
    parameter int PW  = 10,
    parameter int DEF = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          par_ld,
    input  logic [PW-1:0] par_ae,
    input  logic [PW-1:0] par_af,
    input  logic          ser_en,
    input  logic          ser_din,
    output logic [PW-1:0] ae_ofs,
    output logic [PW-1:0] af_ofs
);
    // Reset to defaults, then take parallel or serial updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ae_ofs <= PW'(DEF);
            af_ofs <= PW'(DEF);
        end else if (par_ld) begin
            ae_ofs <= par_ae;
            af_ofs <= par_af;
        end else if (ser_en) begin
            {af_ofs, ae_ofs} <= {af_ofs[PW-2:0], ae_ofs, ser_din};
        end
    end

    // R9: the two load paths are never used in the same cycle.
    p_one_load_path_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(par_ld && ser_en));
endmodule

// File: rtl/dcf_wr_ctl.sv
`timescale 1ns/1ps
// Write-domain control: binary/Gray write pointer, Input Ready and
// Almost-Full, computed against the synchronized read-side pointer.
// Assumes the incoming Gray pointer never runs ahead of the true read pointer.
module dcf_wr_ctl #(
    parameter int DEPTH = 512,
    parameter int PW    = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic [PW-1:0] rq_g,
    input  logic [PW-1:0] af_ofs,
    output logic          wr_fire,
    output logic [PW-1:0] wptr,
    output logic [PW-1:0] wptr_g,
    output logic          in_rdy,
    output logic          af
);
    import dcf_pkg::*;

    logic [PW-1:0] rbin, wptr_nx, used_nx, free_nx;

    // Next-state pointer and fill level for the flag registers.
    always_comb begin
        rbin    = PW'(from_gray(GW'(rq_g)));
        wr_fire = wr_req & in_rdy;
        wptr_nx = wptr + PW'(wr_fire);
        used_nx = wptr_nx - rbin;
        free_nx = PW'(DEPTH) - used_nx;
    end

    // Pointer and write-side flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr   <= '0;
            wptr_g <= '0;
            in_rdy <= 1'b0;
            af     <= 1'b0;
        end else begin
            wptr   <= wptr_nx;
            wptr_g <= PW'(to_gray(GW'(wptr_nx)));
            in_rdy <= (used_nx != PW'(DEPTH));
            af     <= (free_nx <= af_ofs);
        end
    end

    // R3: the write pointer never gets more than DEPTH ahead of the read view.
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (PW'(wptr - rbin) <= PW'(DEPTH)));

    // R5: losing Input Ready means zero free space, which is within any offset.
    p_full_sets_af_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_rdy) |-> af);
endmodule

// File: rtl/dcf_rd_ctl.sv
`timescale 1ns/1ps
// Read-domain control: FWFT read pointer, Output Ready, Almost-Empty,
// retransmit mark and rewind, plus the pointer published to the write side.
// The published pointer walks one step per clock, so its Gray code changes
// at most one bit per cycle even when a retransmit hold is released.
module dcf_rd_ctl #(
    parameter int PW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_req,
    input  logic          rt_hold,
    input  logic          rt_go,
    input  logic [PW-1:0] wq_g,
    input  logic [PW-1:0] ae_ofs,
    output logic [PW-1:0] rptr,
    output logic [PW-1:0] pub_g,
    output logic          out_rdy,
    output logic          ae
);
    import dcf_pkg::*;

    logic [PW-1:0] wbin, mark, pub, target, rptr_nx, cnt_nx, pub_nx;
    logic          hold_q, rd_fire, rewind;

    // Next read pointer, stored count and published pointer step.
    always_comb begin
        wbin    = PW'(from_gray(GW'(wq_g)));
        rd_fire = rd_req & out_rdy;
        rewind  = rt_go & hold_q;
        rptr_nx = rewind ? mark : rptr + PW'(rd_fire);
        cnt_nx  = wbin - rptr_nx;
        target  = hold_q ? mark : rptr;
        pub_nx  = (pub != target) ? pub + 1'b1 : pub;
    end

    // Pointer, mark and read-side flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr    <= '0;
            mark    <= '0;
            hold_q  <= 1'b0;
            pub     <= '0;
            pub_g   <= '0;
            out_rdy <= 1'b0;
            ae      <= 1'b1;
        end else begin
            if (rt_hold && !hold_q) mark <= rptr;
            hold_q  <= rt_hold;
            rptr    <= rptr_nx;
            pub     <= pub_nx;
            pub_g   <= PW'(to_gray(GW'(pub_nx)));
            out_rdy <= (cnt_nx != '0);
            ae      <= (cnt_nx <= ae_ofs);
        end
    end

    // R4: Output Ready never claims a word the write side has not published.
    p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_rdy |-> (wbin != rptr));

    // R6: an empty read side always reports Almost-Empty.
    p_empty_sets_ae_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !out_rdy |-> ae);

    // R11: the pointer crossing to the write side moves by one Gray bit at most.
    p_pub_one_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pub_g ^ $past(pub_g)));
endmodule

// File: rtl/dcfifo_fwft.sv
`timescale 1ns/1ps
// Dual-clock first-word-fall-through FIFO, top level.
// Storage array written on wclk and read asynchronously at the read pointer.
// Assumes DEPTH is a power of two and WIDTH leaves room for both offset fields.
module dcfifo_fwft #(
    parameter int DEPTH   = 512,
    parameter int WIDTH   = 36,
    parameter int DEF_OFS = 8,
    parameter int AF_LSB  = 18
) (
    input  logic             wclk,
    input  logic             rclk,
    input  logic             rst_n,
    input  logic             wr_sel,
    input  logic             wr_en,
    input  logic             wr_cfg,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             ser_en,
    input  logic             ser_din,
    output logic             in_rdy,
    output logic             alm_full,
    input  logic             rd_sel,
    input  logic             rd_en,
    input  logic             rt_hold,
    input  logic             rt_go,
    output logic [WIDTH-1:0] rd_data,
    output logic             out_rdy,
    output logic             alm_empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wptr, wptr_g, wq_g, rptr, pub_g, rq_g, ae_ofs, af_ofs;
    logic             wr_fire;

    dcf_ofs_regs #(.PW(PW), .DEF(DEF_OFS)) u_ofs (
        .clk(wclk), .rst_n(rst_n),
        .par_ld(wr_sel & wr_en & wr_cfg),
        .par_ae(wr_data[PW-1:0]), .par_af(wr_data[AF_LSB +: PW]),
        .ser_en(ser_en), .ser_din(ser_din),
        .ae_ofs(ae_ofs), .af_ofs(af_ofs)
    );

    dcf_wr_ctl #(.DEPTH(DEPTH), .PW(PW)) u_wr (
        .clk(wclk), .rst_n(rst_n),
        .wr_req(wr_sel & wr_en & ~wr_cfg),
        .rq_g(rq_g), .af_ofs(af_ofs),
        .wr_fire(wr_fire), .wptr(wptr), .wptr_g(wptr_g),
        .in_rdy(in_rdy), .af(alm_full)
    );

    dcf_sync2 #(.W(PW)) u_w2r (.clk(rclk), .rst_n(rst_n), .d(wptr_g), .q(wq_g));
    dcf_sync2 #(.W(PW)) u_r2w (.clk(wclk), .rst_n(rst_n), .d(pub_g),  .q(rq_g));

    dcf_rd_ctl #(.PW(PW)) u_rd (
        .clk(rclk), .rst_n(rst_n),
        .rd_req(rd_sel & rd_en),
        .rt_hold(rt_hold), .rt_go(rt_go),
        .wq_g(wq_g), .ae_ofs(ae_ofs),
        .rptr(rptr), .pub_g(pub_g),
        .out_rdy(out_rdy), .ae(alm_empty)
    );

    // Store an accepted word at the write pointer.
    always_ff @(posedge wclk) begin
        if (wr_fire) mem[wptr[AW-1:0]] <= wr_data;
    end

    // Head word falls through to the read port.
    assign rd_data = mem[rptr[AW-1:0]];
endmodule

// File: tb/dcfifo_fwft_test.sv
`timescale 1ns/1ps
module dcfifo_fwft_test;
    localparam int DEPTH = 512;
    localparam int OW    = 10;

    logic        wclk = 0, rclk = 0, rst_n = 0;
    logic        wr_sel = 0, wr_en = 0, wr_cfg = 0, ser_en = 0, ser_din = 0;
    logic        rd_sel = 0, rd_en = 0, rt_hold = 0, rt_go = 0;
    logic [35:0] wr_data = '0;
    logic [35:0] rd_data;
    logic        in_rdy, alm_full, out_rdy, alm_empty;

    int nchk = 0, nfail = 0;
    logic [35:0] q[$];

    always #2.5 wclk = ~wclk;
    always #3.5 rclk = ~rclk;

    dcfifo_fwft uut (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n),
        .wr_sel(wr_sel), .wr_en(wr_en), .wr_cfg(wr_cfg), .wr_data(wr_data),
        .ser_en(ser_en), .ser_din(ser_din),
        .in_rdy(in_rdy), .alm_full(alm_full),
        .rd_sel(rd_sel), .rd_en(rd_en), .rt_hold(rt_hold), .rt_go(rt_go),
        .rd_data(rd_data), .out_rdy(out_rdy), .alm_empty(alm_empty)
    );

    task automatic chk(input string r, input logic [35:0] act, input logic [35:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", r, act, exp);
        end
    endtask

    task automatic settle();
        repeat (8) @(negedge wclk);
        repeat (8) @(negedge rclk);
    endtask

    task automatic push(input logic [35:0] d);
        @(negedge wclk);
        wr_sel = 1; wr_en = 1; wr_data = d;
        if (in_rdy) q.push_back(d);
        @(negedge wclk);
        wr_en = 0; wr_sel = 0;
    endtask

    task automatic pop(input string r);
        logic [35:0] e;
        @(negedge rclk);
        e = q.pop_front();
        chk(r, {35'd0, out_rdy}, 36'd1);
        chk(r, rd_data, e);
        rd_sel = 1; rd_en = 1;
        @(negedge rclk);
        rd_en = 0; rd_sel = 0;
    endtask

    task automatic t_reset();
        repeat (6) @(negedge wclk);
        chk("R7 in_rdy in reset", {35'd0, in_rdy}, 36'd0);
        chk("R7 out_rdy in reset", {35'd0, out_rdy}, 36'd0);
        chk("R7 alm_empty in reset", {35'd0, alm_empty}, 36'd1);
        chk("R7 alm_full in reset", {35'd0, alm_full}, 36'd0);
        @(negedge wclk); rst_n = 1;
        settle();
        chk("R7 in_rdy after reset", {35'd0, in_rdy}, 36'd1);
        chk("R7 out_rdy after reset", {35'd0, out_rdy}, 36'd0);
        chk("R7 alm_empty after reset", {35'd0, alm_empty}, 36'd1);
    endtask

    task automatic t_fwft();
        push(36'hF_0123_4567); push(36'h8_89AB_CDEF); push(36'h7_FFFF_0001);
        settle();
        chk("R1 out_rdy before read", {35'd0, out_rdy}, 36'd1);
        chk("R1 head presented", rd_data, 36'hF_0123_4567);
        chk("R6 three words under default offset", {35'd0, alm_empty}, 36'd1);
        for (int i = 0; i < 3; i++) pop("R2 order");
        settle();
        chk("R2 empty after drain", {35'd0, out_rdy}, 36'd0);
    endtask

    task automatic t_empty_read();
        @(negedge rclk); rd_sel = 1; rd_en = 1;
        repeat (3) @(negedge rclk);
        rd_en = 0; rd_sel = 0;
        push(36'hA_5A5A_5A5A);
        settle();
        chk("R4 word after empty read", rd_data, 36'hA_5A5A_5A5A);
        pop("R4 drain");
    endtask

    task automatic t_select();
        @(negedge wclk); wr_sel = 0; wr_en = 1; wr_data = 36'hD_EAD0_BEEF;
        @(negedge wclk); wr_en = 0;
        settle();
        chk("R12 unselected write", {35'd0, out_rdy}, 36'd0);
        push(36'h1_2345_6789);
        settle();
        @(negedge rclk); rd_sel = 0; rd_en = 1;
        repeat (2) @(negedge rclk); rd_en = 0;
        settle();
        chk("R12 unselected read keeps head", rd_data, 36'h1_2345_6789);
        chk("R12 still ready", {35'd0, out_rdy}, 36'd1);
        pop("R12 drain");
    endtask

    task automatic t_almost_empty();
        for (int i = 0; i < 8; i++) push(36'h3_0000_0000 | 36'(i));
        settle();
        chk("R6 eight words at offset", {35'd0, alm_empty}, 36'd1);
        push(36'h3_0000_0008);
        settle();
        chk("R6 nine words above offset", {35'd0, alm_empty}, 36'd0);
        for (int i = 0; i < 9; i++) pop("R6 drain");
    endtask

    task automatic t_full();
        for (int i = 0; i < DEPTH - 9; i++) push(36'h5_0000_0000 | 36'(i));
        settle();
        chk("R5 nine free", {35'd0, alm_full}, 36'd0);
        push(36'h5_0000_0000 | 36'(DEPTH - 9));
        settle();
        chk("R5 eight free", {35'd0, alm_full}, 36'd1);
        for (int i = DEPTH - 8; i < DEPTH; i++) push(36'h5_0000_0000 | 36'(i));
        settle();
        chk("R3 in_rdy low when full", {35'd0, in_rdy}, 36'd0);
        push(36'hB_AD00_0BAD);
        chk("R3 queue model size", 36'(q.size()), 36'(DEPTH));
        for (int i = 0; i < DEPTH; i++) pop("R3 full drain");
        settle();
        chk("R3 no extra word", {35'd0, out_rdy}, 36'd0);
        chk("R3 in_rdy back", {35'd0, in_rdy}, 36'd1);
    endtask

    task automatic t_parallel();
        @(negedge wclk);
        wr_sel = 1; wr_en = 1; wr_cfg = 1;
        wr_data = (36'd3 << 18) | 36'd2;
        @(negedge wclk); wr_en = 0; wr_sel = 0; wr_cfg = 0;
        settle();
        chk("R8 config write not stored", {35'd0, out_rdy}, 36'd0);
        push(36'h6_0000_0001); push(36'h6_0000_0002);
        settle();
        chk("R8 two words at empty offset 2", {35'd0, alm_empty}, 36'd1);
        push(36'h6_0000_0003);
        settle();
        chk("R8 three words above offset 2", {35'd0, alm_empty}, 36'd0);
        for (int i = 0; i < 3; i++) pop("R8 drain");
    endtask

    task automatic t_serial();
        logic [2*OW-1:0] pat;
        pat = {10'd5, 10'd1};
        for (int i = 2 * OW - 1; i >= 0; i--) begin
            @(negedge wclk); ser_en = 1; ser_din = pat[i];
        end
        @(negedge wclk); ser_en = 0;
        push(36'h7_0000_0001);
        settle();
        chk("R9 one word at empty offset 1", {35'd0, alm_empty}, 36'd1);
        push(36'h7_0000_0002);
        settle();
        chk("R9 two words above offset 1", {35'd0, alm_empty}, 36'd0);
        for (int i = 0; i < 2; i++) pop("R9 drain");
    endtask

    task automatic t_retransmit();
        logic [35:0] keep[$];
        int n;
        for (int i = 0; i < 4; i++) push(36'hC_0000_0000 | 36'(i));
        settle();
        keep = q;
        @(negedge rclk); rt_hold = 1;
        pop("R10 first pass"); pop("R10 first pass");
        @(negedge rclk); rt_go = 1;
        @(negedge rclk); rt_go = 0;
        q = keep;
        chk("R10 head after rewind", rd_data, 36'hC_0000_0000);
        for (int i = 0; i < 4; i++) pop("R10 replay");
        settle();
        chk("R10 empty after replay", {35'd0, out_rdy}, 36'd0);
        n = 0;
        for (int i = 0; i < DEPTH + 20; i++) begin
            @(negedge wclk);
            if (!in_rdy) break;
            wr_sel = 1; wr_en = 1; wr_data = 36'hE_0000_0000 | 36'(i);
            q.push_back(wr_data);
            n++;
        end
        wr_en = 0; wr_sel = 0;
        chk("R11 capacity counted from mark", 36'(n), 36'(DEPTH - 4));
        @(negedge rclk); rt_hold = 0;
        settle();
        chk("R11 space back after release", {35'd0, in_rdy}, 36'd1);
        for (int i = 0; i < DEPTH - 4; i++) pop("R11 drain");
    endtask

    initial begin
        #1000000;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        t_reset();
        t_fwft();
        t_empty_read();
        t_select();
        t_almost_empty();
        t_full();
        t_parallel();
        t_serial();
        t_retransmit();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule